// File: doc/BRIEF.md
# Port Direction Register with Peripheral Override

This block holds the direction setting for one general-purpose I/O port and resolves, pin by pin, whether the pad drives and with what value. The CPU reaches the direction register at one address of a small register window, and only while the option-map select flag is high. With the flag low, that address reads back zero and writes to it have no effect.

A peripheral output function, such as serial data out or a timer event output, can claim a line through a per-line enable. A claimed line becomes an output and drives the peripheral's value in place of the port data latch. The claim leaves the stored direction bit unchanged, so the software setting returns once the peripheral lets go. Register reads always return the stored bits and never the effective directions.

Top module: `portdir_reg`

## Requirements
- R1: After reset the stored direction bits are all 0, so with no peripheral enabled every pinOe bit is 0.
- R2: A write with cpuWrEn=1, optMapSel=1 and cpuAddr equal to DIR_ADDR stores cpuWrData, and the new value is visible on the next clock cycle.
- R3: A write while optMapSel=0 leaves the stored direction bits unchanged.
- R4: A write to any address other than DIR_ADDR leaves the stored direction bits unchanged.
- R5: With optMapSel=1 and cpuAddr equal to DIR_ADDR, cpuRdData shows the stored direction bits combinationally.
- R6: cpuRdData is 0 whenever optMapSel=0 or cpuAddr differs from DIR_ADDR.
- R7: pinOe[i] is 1 when stored bit i is 1 (output) or perEn[i] is 1. It is 0 otherwise, with bit value 0 meaning input.
- R8: pinOut[i] equals perOut[i] while perEn[i] is 1, and latchData[i] otherwise.
- R9: A peripheral enable never alters the stored direction bits. Reads during and after an override return the bits last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| optMapSel | input | 1 | Option-map select flag that gates register access |
| cpuAddr | input | ADDR_W | CPU register address |
| cpuWrEn | input | 1 | CPU write strobe |
| cpuWrData | input | PORT_W | CPU write data |
| cpuRdData | output | PORT_W | CPU read data; zero unless the direction register is selected |
| latchData | input | PORT_W | Port data latch value for each line |
| perEn | input | PORT_W | Per-line peripheral output enable |
| perOut | input | PORT_W | Per-line peripheral output value |
| pinOe | output | PORT_W | Effective per-pin output enable |
| pinOut | output | PORT_W | Effective per-pin output value |

## Verification
The hardest case is a CPU write that lands while a peripheral already claims some lines. The written value must be stored in full even though the pins do not show it, and it must reappear on the pins once the claim drops. The stimulus writes a pattern during an override and then reads the register back with the override still active. It then releases the enable and checks that pinOe returns to the written bits. Random phases mix gated and ungated writes with changing enables, and a behavioural model checks every cycle.

// File: rtl/portdir_pkg.sv
package portdir_pkg;

  typedef struct packed {
    logic dirWr;
    logic dirRd;
  } dirStrobe_t;

endpackage

// File: rtl/portdir_ctrl.sv
module portdir_ctrl
  import portdir_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DIR_ADDR = 2
) (
  input  logic              optMapSel,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWrEn,
  output dirStrobe_t        strobe
);

  localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(DIR_ADDR);

  logic addrHit;

  always_comb begin
    addrHit      = (cpuAddr == SEL_ADDR);
    strobe.dirRd = optMapSel && addrHit;
    strobe.dirWr = optMapSel && addrHit && cpuWrEn;
  end

endmodule

// File: rtl/portdir_dp.sv
module portdir_dp
  import portdir_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dirStrobe_t        strobe,
  input  logic [PORT_W-1:0] wrData,
  input  logic [PORT_W-1:0] latchData,
  input  logic [PORT_W-1:0] perEn,
  input  logic [PORT_W-1:0] perOut,
  output logic [PORT_W-1:0] rdData,
  output logic [PORT_W-1:0] pinOe,
  output logic [PORT_W-1:0] pinOut
);

  logic [PORT_W-1:0] dirBits;

  // Stored software direction; peripheral enables never reach this register.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             dirBits <= '0;
    else if (strobe.dirWr) dirBits <= wrData;
  end

  always_comb begin
    rdData = strobe.dirRd ? dirBits : '0;
  end

  for (genvar i = 0; i < PORT_W; i++) begin : g_pin
    always_comb begin
      pinOe[i]  = dirBits[i] | perEn[i];
      pinOut[i] = perEn[i] ? perOut[i] : latchData[i];
    end
  end

endmodule

// File: rtl/portdir_reg.sv
module portdir_reg
  import portdir_pkg::*;
#(
  parameter int PORT_W   = 8,
  parameter int ADDR_W   = 4,
  parameter int DIR_ADDR = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              optMapSel,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWrEn,
  input  logic [PORT_W-1:0] cpuWrData,
  output logic [PORT_W-1:0] cpuRdData,
  input  logic [PORT_W-1:0] latchData,
  input  logic [PORT_W-1:0] perEn,
  input  logic [PORT_W-1:0] perOut,
  output logic [PORT_W-1:0] pinOe,
  output logic [PORT_W-1:0] pinOut
);

  dirStrobe_t strobe;

  portdir_ctrl #(.ADDR_W(ADDR_W), .DIR_ADDR(DIR_ADDR)) i_ctrl (
    .optMapSel (optMapSel),
    .cpuAddr   (cpuAddr),
    .cpuWrEn   (cpuWrEn),
    .strobe    (strobe)
  );

  portdir_dp #(.PORT_W(PORT_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (cpuWrData),
    .latchData (latchData),
    .perEn     (perEn),
    .perOut    (perOut),
    .rdData    (cpuRdData),
    .pinOe     (pinOe),
    .pinOut    (pinOut)
  );

endmodule

// File: rtl/portdir_chk.sv
module portdir_chk #(
  parameter int PORT_W   = 8,
  parameter int ADDR_W   = 4,
  parameter int DIR_ADDR = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              optMapSel,
  input logic [ADDR_W-1:0] cpuAddr,
  input logic              cpuWrEn,
  input logic [PORT_W-1:0] cpuWrData,
  input logic [PORT_W-1:0] cpuRdData,
  input logic [PORT_W-1:0] latchData,
  input logic [PORT_W-1:0] perEn,
  input logic [PORT_W-1:0] perOut,
  input logic [PORT_W-1:0] pinOe,
  input logic [PORT_W-1:0] pinOut
);

  localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(DIR_ADDR);

  logic wrHit;
  assign wrHit = cpuWrEn && optMapSel && (cpuAddr == SEL_ADDR);

  AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    wrHit |=> (perEn != '0) || (pinOe == $past(cpuWrData))); // R2

  AST_NO_STRAY_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    !wrHit |=> (perEn != '0) || ($past(perEn) != '0) || $stable(pinOe)); // R3

  AST_RD_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (!optMapSel || cpuAddr != SEL_ADDR) |-> cpuRdData == '0); // R6

  AST_OVERRIDE_OE: assert property (@(posedge clk) disable iff (!rstN)
    (pinOe & perEn) == perEn); // R7

  AST_OVERRIDE_VAL: assert property (@(posedge clk) disable iff (!rstN)
    ((pinOut ^ perOut) & perEn) == '0); // R8

  AST_LATCH_VAL: assert property (@(posedge clk) disable iff (!rstN)
    ((pinOut ^ latchData) & ~perEn) == '0); // R8

  AST_READ_MATCHES_OE: assert property (@(posedge clk) disable iff (!rstN)
    (optMapSel && cpuAddr == SEL_ADDR && perEn == '0) |-> cpuRdData == pinOe); // R5

endmodule

bind portdir_reg portdir_chk #(.PORT_W(PORT_W), .ADDR_W(ADDR_W), .DIR_ADDR(DIR_ADDR)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .optMapSel (optMapSel),
  .cpuAddr   (cpuAddr),
  .cpuWrEn   (cpuWrEn),
  .cpuWrData (cpuWrData),
  .cpuRdData (cpuRdData),
  .latchData (latchData),
  .perEn     (perEn),
  .perOut    (perOut),
  .pinOe     (pinOe),
  .pinOut    (pinOut)
);

// File: tb/test_portdir_reg.sv
`timescale 1ns/1ps
module test_portdir_reg;

  localparam int PORT_W   = 8;
  localparam int ADDR_W   = 4;
  localparam int DIR_ADDR = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              optMapSel = 1'b0;
  logic [ADDR_W-1:0] cpuAddr = '0;
  logic              cpuWrEn = 1'b0;
  logic [PORT_W-1:0] cpuWrData = '0;
  logic [PORT_W-1:0] cpuRdData;
  logic [PORT_W-1:0] latchData = '0;
  logic [PORT_W-1:0] perEn = '0;
  logic [PORT_W-1:0] perOut = '0;
  logic [PORT_W-1:0] pinOe;
  logic [PORT_W-1:0] pinOut;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [PORT_W-1:0] refDir = '0;

  always #2 clk = ~clk;

  portdir_reg #(.PORT_W(PORT_W), .ADDR_W(ADDR_W), .DIR_ADDR(DIR_ADDR)) i_portdir_reg (
    .clk(clk), .rstN(rstN), .optMapSel(optMapSel), .cpuAddr(cpuAddr),
    .cpuWrEn(cpuWrEn), .cpuWrData(cpuWrData), .cpuRdData(cpuRdData),
    .latchData(latchData), .perEn(perEn), .perOut(perOut),
    .pinOe(pinOe), .pinOut(pinOut)
  );

  task automatic chk(input string tag, input logic [PORT_W-1:0] act, input logic [PORT_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare every output against the behavioural model, then advance one clock.
  task automatic step(input logic sel, input logic [ADDR_W-1:0] a, input logic we,
                      input logic [PORT_W-1:0] wd, input logic [PORT_W-1:0] ld,
                      input logic [PORT_W-1:0] pe, input logic [PORT_W-1:0] po);
    logic [PORT_W-1:0] expRd;
    logic [PORT_W-1:0] expOut;
    bit hit;
    @(negedge clk);
    optMapSel = sel; cpuAddr = a; cpuWrEn = we; cpuWrData = wd;
    latchData = ld; perEn = pe; perOut = po;
    #1;
    hit = sel && (int'(a) == DIR_ADDR);
    expRd = hit ? refDir : '0;
    chk(hit ? "R5 read stored bits" : "R6 gated read", cpuRdData, expRd);
    chk("R7 output enable", pinOe, refDir | pe);
    for (int i = 0; i < PORT_W; i++) expOut[i] = pe[i] ? po[i] : ld[i];
    chk("R8 output value", pinOut, expOut);
    @(posedge clk);
    if (hit && we) refDir = wd;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R1 reset oe", pinOe, '0);
    rstN = 1'b1;
    // R1: read after reset
    step(1, 4'(DIR_ADDR), 0, 8'h00, 8'h00, 8'h00, 8'h00);
    // R2: write and observe
    step(1, 4'(DIR_ADDR), 1, 8'hA5, 8'h0F, 8'h00, 8'h00);
    step(1, 4'(DIR_ADDR), 0, 8'h00, 8'h0F, 8'h00, 8'h00);
    // R3: write with option map deselected ignored
    step(0, 4'(DIR_ADDR), 1, 8'h3C, 8'hF0, 8'h00, 8'h00);
    step(1, 4'(DIR_ADDR), 0, 8'h00, 8'hF0, 8'h00, 8'h00);
    chk("R3 write ignored", cpuRdData, 8'hA5);
    // R4: write to another address ignored
    step(1, 4'(DIR_ADDR + 1), 1, 8'h11, 8'h00, 8'h00, 8'h00);
    step(1, 4'(DIR_ADDR), 0, 8'h00, 8'h00, 8'h00, 8'h00);
    chk("R4 other address ignored", cpuRdData, 8'hA5);
    // R9: write during override, read while override held, then release
    step(1, 4'(DIR_ADDR), 1, 8'h81, 8'h55, 8'hFF, 8'h0F);
    step(1, 4'(DIR_ADDR), 0, 8'h00, 8'h55, 8'hFF, 8'hF0);
    chk("R9 stored under override", cpuRdData, 8'h81);
    step(1, 4'(DIR_ADDR), 0, 8'h00, 8'h55, 8'h00, 8'h00);
    chk("R9 oe after release", pinOe, 8'h81);
    // R7/R8: partial override patterns
    step(0, 4'(DIR_ADDR), 0, 8'h00, 8'hAA, 8'h18, 8'h10);
    step(1, 4'h0, 0, 8'h00, 8'h33, 8'hC3, 8'h41);
    // Random mix
    for (int n = 0; n < 2000; n++) begin
      logic [ADDR_W-1:0] a;
      a = ($urandom_range(0, 2) == 0) ? ADDR_W'($urandom) : ADDR_W'(DIR_ADDR);
      step(1'($urandom), a, 1'($urandom), PORT_W'($urandom), PORT_W'($urandom),
           ($urandom_range(0, 1) == 0) ? '0 : PORT_W'($urandom), PORT_W'($urandom));
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule